// File: doc/BRIEF.md
# Cascaded CAM chain arbiter

This block is the per-device arbitration logic that allows several content-addressable memory devices to share one bus, stacked one below the other, without any external priority encoder. Each device carries its own page number and a chip-select value. Match and full indications ripple down the stack. Each device combines the indications from above with its own local state. From that result it works out whether it holds the chain's winning match, or the chain's next free slot.

A bus cycle is presented as a valid strobe and a 3-bit cycle kind. One clock later the device asserts either a read output enable or a write accept. It does so only when the chain rules allow this device to answer. The CAM array itself sits outside the block and is represented by the local match, local full and local match index inputs.

Top module: `cam_chain_node`

## Requirements
- R1: `sys_match` is high whenever `up_match` or `local_match` is high, and low otherwise (combinational).
- R2: `sys_full` is high only when both `up_full` and `local_full` are high (combinational).
- R3: The page register resets to 0 and loads `cfg_data` on a clock edge with `cfg_page_wr` high. `status_addr` is the page register concatenated above `local_idx`.
- R4: The select register resets to all ones and loads `cfg_data` on an edge with `cfg_sel_wr` high. The device is selected when the select register equals the page register or is all ones.
- R5: `hpm_owner` = `local_match` and not `up_match`. A status read (kind 3) sets `rsp_drive` on the next cycle only on the owner.
- R6: A memory read (kind 0) or register read (kind 1) sets `rsp_drive` on the next cycle only if the device is selected and `local_match` is high. Otherwise the read is blocked.
- R7: A next-free register read (kind 2) sets `rsp_drive` on the next cycle whenever the device is selected, whatever the match state.
- R8: A highest-match write (kind 4) sets `rsp_accept` on the next cycle only when `hpm_owner` is high, whatever the select value.
- R9: `nf_owner` = `up_full` and not `local_full`. A next-free write (kind 5) sets `rsp_accept` on the next cycle only when `nf_owner` is high.
- R10: A general write (kind 6) sets `rsp_accept` on the next cycle whenever the device is selected.
- R11: With no valid cycle, or with the reserved kind 7, both `rsp_drive` and `rsp_accept` are low on the next cycle. A read never raises `rsp_accept`, and a write never raises `rsp_drive`. Both are low during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_page_wr | input | 1 | Load page register from cfg_data |
| cfg_sel_wr | input | 1 | Load select register from cfg_data |
| cfg_data | input | PAGE_W | Configuration value |
| up_match | input | 1 | Some earlier device matched (tie low on first device) |
| up_full | input | 1 | All earlier devices full (tie high on first device) |
| local_match | input | 1 | Local array matched in last compare |
| local_full | input | 1 | Local array has no free slot |
| local_idx | input | IDX_W | Local highest-priority match index |
| cyc_valid | input | 1 | Bus cycle present |
| cyc_kind | input | 3 | Cycle kind code (see R5 to R11) |
| sys_match | output | 1 | Qualified match to next device |
| sys_full | output | 1 | Qualified full to next device |
| status_addr | output | PAGE_W+IDX_W | Full match address {page, index} |
| hpm_owner | output | 1 | This device holds the chain's winning match |
| nf_owner | output | 1 | This device holds the chain's next free slot |
| rsp_drive | output | 1 | Read output enable, one cycle after request |
| rsp_accept | output | 1 | Write accept, one cycle after request |

## Verification
The hardest case is a device that is selected and holds a local match while an earlier device has already reported one. Memory reads must still be driven in that case, but highest-match reads and writes must be refused. The stimulus gets there by holding `up_match` high and `local_match` high together, and then repeating the same cycle kinds with `up_match` low. A second hard case is a device that is not full while the chain above is only partly full. The bench covers it by toggling `up_full` around next-free writes. Select decoding is driven with a matching page, a mismatching page and the broadcast value.

// File: rtl/cam_chain_pkg.sv
package cam_chain_pkg;

    typedef enum logic [2:0] {
        CK_RD_MEM    = 3'd0,
        CK_RD_REG    = 3'd1,
        CK_RD_NFREG  = 3'd2,
        CK_RD_STATUS = 3'd3,
        CK_WR_HPM    = 3'd4,
        CK_WR_NF     = 3'd5,
        CK_WR_OTHER  = 3'd6,
        CK_RESERVED  = 3'd7
    } cyc_kind_e;

    typedef struct packed {
        logic sys_match;
        logic sys_full;
        logic hpm_own;
        logic nf_own;
    } chain_flags_t;

    typedef struct packed {
        logic drive;
        logic accept;
    } chain_rsp_t;

    function automatic logic kind_is_read(input cyc_kind_e k);
        return (k == CK_RD_MEM) || (k == CK_RD_REG) ||
               (k == CK_RD_NFREG) || (k == CK_RD_STATUS);
    endfunction

endpackage

// File: rtl/cam_chain_flags.sv
module cam_chain_flags
    import cam_chain_pkg::*;
(
    input  logic         up_match,
    input  logic         up_full,
    input  logic         local_match,
    input  logic         local_full,
    output chain_flags_t flags
);
    always_comb begin
        flags.sys_match = up_match | local_match;
        flags.sys_full  = up_full & local_full;
        flags.hpm_own   = local_match & ~up_match;
        flags.nf_own    = up_full & ~local_full;
    end
endmodule

// File: rtl/cam_chain_select.sv
module cam_chain_select #(
    parameter int PAGE_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              page_wr,
    input  logic              sel_wr,
    input  logic [PAGE_W-1:0] wdata,
    output logic [PAGE_W-1:0] page_q,
    output logic              selected
);
    localparam logic [PAGE_W-1:0] BCAST = {PAGE_W{1'b1}};

    logic [PAGE_W-1:0] sel_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            page_q <= '0;
            sel_q  <= BCAST;
        end else begin
            if (page_wr) page_q <= wdata;
            if (sel_wr)  sel_q  <= wdata;
        end
    end

    always_comb selected = (sel_q == BCAST) || (sel_q == page_q);
endmodule

// File: rtl/cam_chain_grant.sv
module cam_chain_grant
    import cam_chain_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         cyc_valid,
    input  cyc_kind_e    kind,
    input  logic         selected,
    input  logic         local_match,
    input  chain_flags_t flags,
    output chain_rsp_t   rsp
);
    chain_rsp_t rsp_d;

    always_comb begin
        rsp_d = '0;
        if (cyc_valid) begin
            unique case (kind)
                CK_RD_MEM,
                CK_RD_REG:    rsp_d.drive  = selected & local_match;
                CK_RD_NFREG:  rsp_d.drive  = selected;
                CK_RD_STATUS: rsp_d.drive  = flags.hpm_own;
                CK_WR_HPM:    rsp_d.accept = flags.hpm_own;
                CK_WR_NF:     rsp_d.accept = flags.nf_own;
                CK_WR_OTHER:  rsp_d.accept = selected;
                default:      rsp_d        = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rsp <= '0;
        else     rsp <= rsp_d;
    end
endmodule

// File: rtl/cam_chain_node.sv
module cam_chain_node
    import cam_chain_pkg::*;
#(
    parameter int PAGE_W = 16,
    parameter int IDX_W  = 8,
    localparam int ADDR_W = PAGE_W + IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_page_wr,
    input  logic              cfg_sel_wr,
    input  logic [PAGE_W-1:0] cfg_data,
    input  logic              up_match,
    input  logic              up_full,
    input  logic              local_match,
    input  logic              local_full,
    input  logic [IDX_W-1:0]  local_idx,
    input  logic              cyc_valid,
    input  logic [2:0]        cyc_kind,
    output logic              sys_match,
    output logic              sys_full,
    output logic [ADDR_W-1:0] status_addr,
    output logic              hpm_owner,
    output logic              nf_owner,
    output logic              rsp_drive,
    output logic              rsp_accept
);
    chain_flags_t      flags;
    chain_rsp_t        rsp;
    logic [PAGE_W-1:0] page_q;
    logic              selected;

    cam_chain_flags u_flags (
        .up_match    (up_match),
        .up_full     (up_full),
        .local_match (local_match),
        .local_full  (local_full),
        .flags       (flags)
    );

    cam_chain_select #(.PAGE_W(PAGE_W)) u_select (
        .clk      (clk),
        .rst      (rst),
        .page_wr  (cfg_page_wr),
        .sel_wr   (cfg_sel_wr),
        .wdata    (cfg_data),
        .page_q   (page_q),
        .selected (selected)
    );

    cam_chain_grant u_grant (
        .clk         (clk),
        .rst         (rst),
        .cyc_valid   (cyc_valid),
        .kind        (cyc_kind_e'(cyc_kind)),
        .selected    (selected),
        .local_match (local_match),
        .flags       (flags),
        .rsp         (rsp)
    );

    assign sys_match   = flags.sys_match;
    assign sys_full    = flags.sys_full;
    assign hpm_owner   = flags.hpm_own;
    assign nf_owner    = flags.nf_own;
    assign status_addr = {page_q, local_idx};
    assign rsp_drive   = rsp.drive;
    assign rsp_accept  = rsp.accept;
endmodule

// File: rtl/cam_chain_node_chk.sv
module cam_chain_node_chk (
    input logic       clk,
    input logic       rst,
    input logic       up_match,
    input logic       up_full,
    input logic       local_match,
    input logic       local_full,
    input logic       cyc_valid,
    input logic [2:0] cyc_kind,
    input logic       sys_match,
    input logic       sys_full,
    input logic       rsp_drive,
    input logic       rsp_accept
);
    // R1
    match_chain_chk: assert property (@(posedge clk) disable iff (rst)
        (up_match || local_match) |-> sys_match);
    // R2
    full_chain_chk: assert property (@(posedge clk) disable iff (rst)
        sys_full |-> (up_full && local_full));
    // R5
    status_owner_chk: assert property (@(posedge clk) disable iff (rst)
        (cyc_valid && cyc_kind == 3'd3 && up_match) |=> !rsp_drive);
    // R8
    hpm_write_chk: assert property (@(posedge clk) disable iff (rst)
        (cyc_valid && cyc_kind == 3'd4 && !local_match) |=> !rsp_accept);
    // R9
    nf_write_chk: assert property (@(posedge clk) disable iff (rst)
        (cyc_valid && cyc_kind == 3'd5 && (local_full || !up_full)) |=> !rsp_accept);
    // R6
    blocked_read_chk: assert property (@(posedge clk) disable iff (rst)
        (cyc_valid && cyc_kind <= 3'd1 && !local_match) |=> !rsp_drive);
    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!cyc_valid || cyc_kind == 3'd7) |=> (!rsp_drive && !rsp_accept));
    // R11
    rsp_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(rsp_drive && rsp_accept));
endmodule

bind cam_chain_node cam_chain_node_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .up_match    (up_match),
    .up_full     (up_full),
    .local_match (local_match),
    .local_full  (local_full),
    .cyc_valid   (cyc_valid),
    .cyc_kind    (cyc_kind),
    .sys_match   (sys_match),
    .sys_full    (sys_full),
    .rsp_drive   (rsp_drive),
    .rsp_accept  (rsp_accept)
);

// File: tb/cam_chain_node_bench.sv
module cam_chain_node_bench;
    localparam int PAGE_W = 16;
    localparam int IDX_W  = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_page_wr = 1'b0, cfg_sel_wr = 1'b0;
    logic [PAGE_W-1:0] cfg_data = '0;
    logic up_match = 1'b0, up_full = 1'b1, local_match = 1'b0, local_full = 1'b0;
    logic [IDX_W-1:0] local_idx = '0;
    logic cyc_valid = 1'b0;
    logic [2:0] cyc_kind = 3'd0;
    logic sys_match, sys_full, hpm_owner, nf_owner, rsp_drive, rsp_accept;
    logic [PAGE_W+IDX_W-1:0] status_addr;

    int n_chk = 0;
    int n_fail = 0;
    logic done = 1'b0;

    always #10 clk = ~clk;

    cam_chain_node #(.PAGE_W(PAGE_W), .IDX_W(IDX_W)) u_cam_chain_node (
        .clk(clk), .rst(rst), .cfg_page_wr(cfg_page_wr), .cfg_sel_wr(cfg_sel_wr),
        .cfg_data(cfg_data), .up_match(up_match), .up_full(up_full),
        .local_match(local_match), .local_full(local_full), .local_idx(local_idx),
        .cyc_valid(cyc_valid), .cyc_kind(cyc_kind), .sys_match(sys_match),
        .sys_full(sys_full), .status_addr(status_addr), .hpm_owner(hpm_owner),
        .nf_owner(nf_owner), .rsp_drive(rsp_drive), .rsp_accept(rsp_accept)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Issue one cycle, then sample both responses one clock later.
    task automatic bus_cycle(input logic [2:0] k, input string req,
                             input logic exp_drv, input logic exp_acc);
        @(negedge clk);
        cyc_valid = 1'b1;
        cyc_kind  = k;
        @(negedge clk);
        cyc_valid = 1'b0;
        check({req, " drive"},  {31'd0, rsp_drive},  {31'd0, exp_drv});
        check({req, " accept"}, {31'd0, rsp_accept}, {31'd0, exp_acc});
    endtask

    task automatic cfg_write(input logic page, input logic [PAGE_W-1:0] v);
        @(negedge clk);
        cfg_data    = v;
        cfg_page_wr = page;
        cfg_sel_wr  = ~page;
        @(negedge clk);
        cfg_page_wr = 1'b0;
        cfg_sel_wr  = 1'b0;
    endtask

    task automatic t_reset;
        check("R11 reset drive",  {31'd0, rsp_drive},  32'd0);
        check("R11 reset accept", {31'd0, rsp_accept}, 32'd0);
        local_idx = 8'h5A;
        #1;
        check("R3 reset page", {8'd0, status_addr}, 32'h0000_5A);
        // broadcast select after reset: next-free reg read answered
        bus_cycle(3'd2, "R4 reset broadcast", 1'b1, 1'b0);
    endtask

    task automatic t_flags;
        for (int i = 0; i < 16; i++) begin
            {up_match, up_full, local_match, local_full} = 4'(i);
            #1;
            check("R1 sys_match", {31'd0, sys_match}, {31'd0, up_match | local_match});
            check("R2 sys_full",  {31'd0, sys_full},  {31'd0, up_full & local_full});
            check("R5 hpm_owner", {31'd0, hpm_owner}, {31'd0, local_match & ~up_match});
            check("R9 nf_owner",  {31'd0, nf_owner},  {31'd0, up_full & ~local_full});
        end
    endtask

    task automatic t_select;
        cfg_write(1'b1, 16'h0003);
        local_idx = 8'hC1;
        #1;
        check("R3 page load", {8'd0, status_addr}, 32'h0003_C1);
        up_match = 0; up_full = 1; local_match = 0; local_full = 0;
        cfg_write(1'b0, 16'h0007);
        bus_cycle(3'd2, "R7 deselected nfreg", 1'b0, 1'b0);
        bus_cycle(3'd6, "R10 deselected write", 1'b0, 1'b0);
        cfg_write(1'b0, 16'h0003);
        bus_cycle(3'd2, "R7 selected nfreg no match", 1'b1, 1'b0);
        bus_cycle(3'd6, "R10 selected write", 1'b0, 1'b1);
        cfg_write(1'b0, 16'hFFFF);
        bus_cycle(3'd6, "R4 broadcast write", 1'b0, 1'b1);
    endtask

    task automatic t_reads;
        local_match = 0; up_match = 0;
        bus_cycle(3'd0, "R6 mem read no match", 1'b0, 1'b0);
        bus_cycle(3'd1, "R6 reg read no match", 1'b0, 1'b0);
        bus_cycle(3'd3, "R5 status no match", 1'b0, 1'b0);
        local_match = 1; up_match = 1;
        bus_cycle(3'd0, "R6 mem read match", 1'b1, 1'b0);
        bus_cycle(3'd3, "R5 status earlier winner", 1'b0, 1'b0);
        bus_cycle(3'd4, "R8 hpm write earlier winner", 1'b0, 1'b0);
        up_match = 0;
        bus_cycle(3'd3, "R5 status owner", 1'b1, 1'b0);
        bus_cycle(3'd4, "R8 hpm write owner", 1'b0, 1'b1);
        cfg_write(1'b0, 16'h0009);
        bus_cycle(3'd1, "R6 reg read deselected", 1'b0, 1'b0);
        bus_cycle(3'd4, "R8 hpm write ignores select", 1'b0, 1'b1);
        cfg_write(1'b0, 16'hFFFF);
    endtask

    task automatic t_nextfree;
        up_full = 0; local_full = 0;
        bus_cycle(3'd5, "R9 nf write upstream not full", 1'b0, 1'b0);
        up_full = 1; local_full = 1;
        bus_cycle(3'd5, "R9 nf write local full", 1'b0, 1'b0);
        local_full = 0;
        bus_cycle(3'd5, "R9 nf write owner", 1'b0, 1'b1);
    endtask

    task automatic t_idle;
        local_match = 1; up_match = 0;
        bus_cycle(3'd7, "R11 reserved kind", 1'b0, 1'b0);
        @(negedge clk);
        @(negedge clk);
        check("R11 idle drive",  {31'd0, rsp_drive},  32'd0);
        check("R11 idle accept", {31'd0, rsp_accept}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_flags();
        t_select();
        t_reads();
        t_nextfree();
        t_idle();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_chk++;
                n_fail++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule